// File: doc/BRIEF.md
# Cable Impedance Tuning Sequencer

This block steps a 10/100 Ethernet PHY through its cable-compensation tuning after the interface comes up. A periodic tick from a timer paces it: each accepted tick runs one step, and one step is a short burst of accesses on a register-bus master port. The port has a request that stays high until acknowledge, plus a write enable, an address, write data and read data. A step may read the 16-bit configuration/status register or write 32-bit words to the N-way test register and the two compensation registers.

The first step checks whether the link is up. If the link is down, the block writes a fixed set of safe defaults and stops. If the link is up, a second step reads a 4-bit echo-delay field, which selects one row of a built-in 4x4 table of compensation words. The block then writes that row to the upper compensation register, one column per tick. When the longest-cable row has been used, a re-check step confirms the reading. If the reading has changed, the block restores defaults and replays the next shorter-cable row. While tuning is in progress, the block asks its timer for ticks ten times faster than the base period. When tuning ends, it asks for the base period again.

Top module: `cable_tune_seq`

## Requirements
- R1: After reset, done_o is 1, busy_o is 0, reg_req_o is 0 and tick_period_o equals BASE_PERIOD; tuning stays off until start_i is pulsed while busy_o is 0.
- R2: The first tick after start_i reads the configuration register (address 0x74 by default).
- R3: If bit 10 of that read is 1, the step writes 0x03C0 to address 0x74 and does not finish tuning.
- R4: If bit 10 is 0, the step writes, in this order: 0xF3C0 to 0x74, 0x00000020 to the N-way test register (0x70), 0x78FA8388 to 0x78, and 0xCB38DE43 to 0x7C. Tuning then ends.
- R5: The next tick reads 0x74 and takes the row from read bits [15:12]: 7 selects row 3, 3 selects row 2, 1 selects row 1, and any other value selects row 0.
- R6: Each of the next four ticks writes one table word to 0x7C, in column order 0 to 3. Column 0 is preceded by a write of 0 to 0x70. Table rows by column: row 0 CB39DE43, CB39CE43, FB38DE03, CB38DE43; rows 1 and 2 CB39DE43, CB39CE43, CB39CE83, CB39CE83; row 3 BB39DE43, BB39CE43, BB39CE83, BB39CE83.
- R7: After column 3 of rows 0 to 2, tuning ends and no register requests are issued while done_o is 1.
- R8: After column 3 of row 3, the next tick reads 0x74. If bits [15:12] still equal 7, tuning ends. Otherwise the step writes 0xFB38DE03 to 0x7C. The following tick then writes 0x20 to 0x70, 0x78FA8388 to 0x78, 0xCB38DE43 to 0x7C and 0 to 0x70, in that order, and tuning resumes at column 0 of the row below. The row never goes below 0.
- R9: Each access holds reg_req_o, reg_we_o, reg_addr_o and reg_wdata_o steady until reg_ack_i. The block issues only one access at a time.
- R10: A tick that arrives while a step is running, or while done_o is 1, is ignored.
- R11: tick_period_o equals BASE_PERIOD/10 while tuning is active and BASE_PERIOD while done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that restarts tuning at the link check |
| tick_i | input | 1 | Pacing tick; one step per accepted tick |
| reg_req_o | output | 1 | Register access request, held until acknowledge |
| reg_we_o | output | 1 | 1 for write, 0 for read |
| reg_addr_o | output | 8 | Register offset |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 16 | Read data of the configuration/status register |
| reg_ack_i | input | 1 | Access complete; read data valid |
| tick_period_o | output | PERIOD_W | Requested interval until the next tick |
| busy_o | output | 1 | A step is running |
| done_o | output | 1 | Tuning is finished or disabled |

## Verification
An accepted tick raises busy_o on the next edge. The first request appears one edge after that. Each further request follows one edge after the previous acknowledge. The step ends one edge after its last acknowledge, and on that same edge busy_o falls and the new done_o and tick_period_o values appear. For this reason the bench does not count cycles between a tick and its results. It waits for busy_o to fall, sampling on the falling clock edge, and only then compares the access log and the outputs. This keeps each check correct for any acknowledge latency the bus model uses. To test R10, extra ticks are driven one cycle after busy_o has risen. The bench then confirms that the access log for that step is unchanged and that busy_o stays low afterwards.

// File: rtl/cable_tune_pkg.sv
package cable_tune_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int CFG_W    = 16;
  localparam int ROW_W    = 2;
  localparam int COL_W    = 2;
  localparam int IDX_W    = 3;
  localparam int LINK_BIT = 10;

  localparam logic [CFG_W-1:0]  CFG_LINK_UP   = 16'h03C0;
  localparam logic [CFG_W-1:0]  CFG_LINK_DOWN = 16'hF3C0;
  localparam logic [DATA_W-1:0] NWAY_CABLE    = 32'h0000_0020;
  localparam logic [DATA_W-1:0] NWAY_CLEAR    = 32'h0000_0000;
  localparam logic [DATA_W-1:0] LOW_DEFAULT   = 32'h78FA_8388;
  localparam logic [DATA_W-1:0] HIGH_DEFAULT  = 32'hCB38_DE43;
  localparam logic [DATA_W-1:0] HIGH_BACKOFF  = 32'hFB38_DE03;

  typedef enum logic [2:0] {
    ST_OFF, ST_LINK, ST_ROW, ST_PARAM, ST_RECHK, ST_RETUNE
  } tune_st_e;

  typedef enum logic [1:0] {OP_RD, OP_WR, OP_END} op_kind_e;

  function automatic logic [DATA_W-1:0] tune_word(input logic [ROW_W-1:0] row,
                                                  input logic [COL_W-1:0] col);
    logic [DATA_W-1:0] w;
    unique case (col)
      2'd0: w = 32'hCB39_DE43;
      2'd1: w = 32'hCB39_CE43;
      default: w = 32'hCB39_CE83;
    endcase
    if (row == 2'd0) begin
      if (col == 2'd2) w = 32'hFB38_DE03;
      if (col == 2'd3) w = 32'hCB38_DE43;
    end
    if (row == 2'd3) w = {4'hB, w[27:0]};
    return w;
  endfunction
endpackage

// File: rtl/cable_tune_table.sv
module cable_tune_table
  import cable_tune_pkg::*;
(
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [DATA_W-1:0] word_o
);
  always_comb word_o = tune_word(row_i, col_i);
endmodule

// File: rtl/cable_tune_class.sv
module cable_tune_class
  import cable_tune_pkg::*;
(
  input  logic [3:0]       field_i,
  output logic [ROW_W-1:0] row_o,
  output logic             long_o
);
  always_comb begin
    unique case (field_i)
      4'h7:    row_o = 2'd3;
      4'h3:    row_o = 2'd2;
      4'h1:    row_o = 2'd1;
      default: row_o = 2'd0;
    endcase
    long_o = (field_i == 4'h7);
  end
endmodule

// File: rtl/cable_tune_port.sv
module cable_tune_port
  import cable_tune_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              idle_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (req_o) begin
      if (ack_i) req_o <= 1'b0;
    end else if (issue_i) begin
      req_o   <= 1'b1;
      we_o    <= we_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  assign idle_o = !req_o;
  assign done_o = req_o && ack_i;

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(wdata_o) && $stable(we_o));
  assert_req_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !req_o);
endmodule

// File: rtl/cable_tune_seq.sv
module cable_tune_seq
  import cable_tune_pkg::*;
#(
  parameter logic [7:0] ADDR_CFG    = 8'h74,
  parameter logic [7:0] ADDR_NWAY   = 8'h70,
  parameter logic [7:0] ADDR_LOW    = 8'h78,
  parameter logic [7:0] ADDR_HIGH   = 8'h7C,
  parameter int         BASE_PERIOD = 1000,
  parameter int         PERIOD_W    = $clog2(BASE_PERIOD + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                tick_i,
  output logic                reg_req_o,
  output logic                reg_we_o,
  output logic [7:0]          reg_addr_o,
  output logic [31:0]         reg_wdata_o,
  input  logic [15:0]         reg_rdata_i,
  input  logic                reg_ack_i,
  output logic [PERIOD_W-1:0] tick_period_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int FAST_PERIOD = BASE_PERIOD / 10;

  tune_st_e          st_q;
  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              link_q;
  logic [3:0]        field_q;

  op_kind_e          op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [DATA_W-1:0] tbl_word;
  logic [ROW_W-1:0]  cls_row;
  logic              cls_long;
  logic              port_idle, port_done, issue;
  logic              unused_rd_bits;

  assign unused_rd_bits = ^{reg_rdata_i[11], reg_rdata_i[9:0]};

  cable_tune_table u_table (.row_i(row_q), .col_i(col_q), .word_o(tbl_word));
  cable_tune_class u_class (.field_i(field_q), .row_o(cls_row), .long_o(cls_long));

  // Micro-op list of the running step, indexed by idx_q
  always_comb begin
    op_kind = OP_END;
    op_addr = ADDR_CFG;
    op_data = '0;
    unique case (st_q)
      ST_LINK: begin
        if (idx_q == 3'd0) op_kind = OP_RD;
        else if (link_q) begin
          if (idx_q == 3'd1) begin
            op_kind = OP_WR; op_data = {16'h0, CFG_LINK_UP};
          end
        end else begin
          unique case (idx_q)
            3'd1: begin op_kind = OP_WR; op_data = {16'h0, CFG_LINK_DOWN}; end
            3'd2: begin op_kind = OP_WR; op_addr = ADDR_NWAY; op_data = NWAY_CABLE; end
            3'd3: begin op_kind = OP_WR; op_addr = ADDR_LOW;  op_data = LOW_DEFAULT; end
            3'd4: begin op_kind = OP_WR; op_addr = ADDR_HIGH; op_data = HIGH_DEFAULT; end
            default: ;
          endcase
        end
      end
      ST_ROW: if (idx_q == 3'd0) op_kind = OP_RD;
      ST_PARAM: begin
        if (col_q == '0) begin
          if (idx_q == 3'd0) begin
            op_kind = OP_WR; op_addr = ADDR_NWAY; op_data = NWAY_CLEAR;
          end else if (idx_q == 3'd1) begin
            op_kind = OP_WR; op_addr = ADDR_HIGH; op_data = tbl_word;
          end
        end else if (idx_q == 3'd0) begin
          op_kind = OP_WR; op_addr = ADDR_HIGH; op_data = tbl_word;
        end
      end
      ST_RECHK: begin
        if (idx_q == 3'd0) op_kind = OP_RD;
        else if (idx_q == 3'd1 && !cls_long) begin
          op_kind = OP_WR; op_addr = ADDR_HIGH; op_data = HIGH_BACKOFF;
        end
      end
      ST_RETUNE: begin
        unique case (idx_q)
          3'd0: begin op_kind = OP_WR; op_addr = ADDR_NWAY; op_data = NWAY_CABLE; end
          3'd1: begin op_kind = OP_WR; op_addr = ADDR_LOW;  op_data = LOW_DEFAULT; end
          3'd2: begin op_kind = OP_WR; op_addr = ADDR_HIGH; op_data = HIGH_DEFAULT; end
          3'd3: begin op_kind = OP_WR; op_addr = ADDR_NWAY; op_data = NWAY_CLEAR; end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign issue = busy_q && (op_kind != OP_END) && port_idle;

  cable_tune_port u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .we_i    (op_kind == OP_WR),
    .addr_i  (op_addr),
    .wdata_i (op_data),
    .ack_i   (reg_ack_i),
    .req_o   (reg_req_o),
    .we_o    (reg_we_o),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o),
    .idle_o  (port_idle),
    .done_o  (port_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_OFF;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      row_q   <= '0;
      col_q   <= '0;
      link_q  <= 1'b0;
      field_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        st_q  <= ST_LINK;
        row_q <= '0;
        col_q <= '0;
      end else if (tick_i && st_q != ST_OFF) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (port_done) begin
      idx_q <= idx_q + 1'b1;
      if (!reg_we_o) begin
        link_q  <= reg_rdata_i[LINK_BIT];
        field_q <= reg_rdata_i[15:12];
      end
    end else if (op_kind == OP_END) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      unique case (st_q)
        ST_LINK:  st_q <= link_q ? ST_ROW : ST_OFF;
        ST_ROW: begin
          row_q <= cls_row;
          col_q <= '0;
          st_q  <= ST_PARAM;
        end
        ST_PARAM: begin
          col_q <= col_q + 1'b1;
          if (col_q == '1) st_q <= (row_q == '1) ? ST_RECHK : ST_OFF;
        end
        ST_RECHK: st_q <= cls_long ? ST_OFF : ST_RETUNE;
        ST_RETUNE: begin
          row_q <= (row_q == '0) ? '0 : row_q - 1'b1;
          col_q <= '0;
          st_q  <= ST_PARAM;
        end
        default: st_q <= ST_OFF;
      endcase
    end
  end

  assign busy_o        = busy_q;
  assign done_o        = (st_q == ST_OFF);
  assign tick_period_o = done_o ? PERIOD_W'(BASE_PERIOD) : PERIOD_W'(FAST_PERIOD);

  assert_step_from_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(tick_i));
  assert_done_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !reg_req_o && !busy_o);
  assert_rechk_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_RECHK) && (st_q != ST_RECHK) |-> (st_q == ST_OFF) || (st_q == ST_RETUNE));
  assert_retune_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_RETUNE) && (st_q == ST_PARAM) |-> (col_q == '0) && (row_q != '1));
endmodule

// File: tb/cable_tune_seq_tb_top.sv
module cable_tune_seq_tb_top;
  localparam int BASE = 1000;
  localparam int PW   = $clog2(BASE + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          tick_i = 1'b0;
  logic          reg_req_o, reg_we_o, busy_o, done_o;
  logic [7:0]    reg_addr_o;
  logic [31:0]   reg_wdata_o;
  logic [15:0]   cfg_val = 16'h0;
  logic          reg_ack_i = 1'b0;
  logic [PW-1:0] tick_period_o;

  int checks = 0;
  int failures = 0;
  int lat = 2;
  int ack_cnt = 0;
  int log_n = 0;
  int base_n = 0;
  logic [40:0] log_q [256];

  always #2.5 clk_i = ~clk_i;

  cable_tune_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tick_i(tick_i),
    .reg_req_o(reg_req_o), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(cfg_val), .reg_ack_i(reg_ack_i),
    .tick_period_o(tick_period_o), .busy_o(busy_o), .done_o(done_o)
  );

  // Register-bus responder and access logger
  always @(posedge clk_i) begin
    if (!reg_req_o || reg_ack_i) begin
      reg_ack_i <= 1'b0;
      ack_cnt   <= 0;
    end else if (ack_cnt >= lat) reg_ack_i <= 1'b1;
    else ack_cnt <= ack_cnt + 1;
    if (reg_req_o && reg_ack_i) begin
      log_q[log_n[7:0]] <= {reg_we_o, reg_addr_o, reg_we_o ? reg_wdata_o : 32'h0};
      log_n <= log_n + 1;
    end
  end

  function automatic logic [40:0] ent(input logic we, input logic [7:0] a, input logic [31:0] d);
    return {we, a, we ? d : 32'h0};
  endfunction

  function automatic logic [31:0] exp_word(input int row, input int col);
    logic [31:0] r0 [4] = '{32'hCB39DE43, 32'hCB39CE43, 32'hFB38DE03, 32'hCB38DE43};
    logic [31:0] r1 [4] = '{32'hCB39DE43, 32'hCB39CE43, 32'hCB39CE83, 32'hCB39CE83};
    logic [31:0] r3 [4] = '{32'hBB39DE43, 32'hBB39CE43, 32'hBB39CE83, 32'hBB39CE83};
    if (row == 0) return r0[col];
    if (row == 3) return r3[col];
    return r1[col];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_n(input int n, input string req);
    chk((log_n - base_n) == n, {req, " access count"}, 64'(log_n - base_n), 64'(n));
  endtask

  task automatic chk_acc(input int k, input logic [40:0] e, input string req);
    logic [40:0] a;
    a = log_q[(base_n + k) % 256];
    chk(a === e, req, 64'(a), 64'(e));
  endtask

  task automatic do_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  // One tick-paced step; dbl adds a tick while the step is running
  task automatic step(input bit dbl);
    int guard;
    base_n = log_n;
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
    if (dbl) begin
      @(negedge clk_i) tick_i = 1'b1;
      @(negedge clk_i) tick_i = 1'b0;
    end
    guard = 0;
    while (busy_o && guard < 200) begin
      @(negedge clk_i);
      guard++;
    end
    chk(guard < 200, "R9 step completes", 64'(guard), 64'(0));
  endtask

  task automatic t_reset();
    chk(done_o == 1'b1, "R1 done after reset", 64'(done_o), 64'(1));
    chk(busy_o == 1'b0, "R1 idle after reset", 64'(busy_o), 64'(0));
    chk(reg_req_o == 1'b0, "R1 no request", 64'(reg_req_o), 64'(0));
    chk(tick_period_o == PW'(BASE), "R11 slow period", 64'(tick_period_o), 64'(BASE));
  endtask

  task automatic t_tick_while_done();
    base_n = log_n;
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
    repeat (6) @(negedge clk_i);
    chk_n(0, "R10 tick while done");
    chk(busy_o == 1'b0, "R10 no step while done", 64'(busy_o), 64'(0));
  endtask

  task automatic t_link_down();
    cfg_val = 16'h0000;
    do_start();
    chk(tick_period_o == PW'(BASE / 10), "R11 fast while tuning", 64'(tick_period_o), 64'(BASE / 10));
    chk(done_o == 1'b0, "R1 start enables tuning", 64'(done_o), 64'(0));
    step(1'b0);
    chk_n(5, "R4");
    chk_acc(0, ent(1'b0, 8'h74, 0), "R2 link read");
    chk_acc(1, ent(1'b1, 8'h74, 32'hF3C0), "R4 cfg down");
    chk_acc(2, ent(1'b1, 8'h70, 32'h20), "R4 cable test");
    chk_acc(3, ent(1'b1, 8'h78, 32'h78FA8388), "R4 low default");
    chk_acc(4, ent(1'b1, 8'h7C, 32'hCB38DE43), "R4 high default");
    chk(done_o == 1'b1, "R4 done", 64'(done_o), 64'(1));
    chk(tick_period_o == PW'(BASE), "R11 slow after done", 64'(tick_period_o), 64'(BASE));
  endtask

  // Link check, row classification and the four columns of one row
  task automatic run_row(input logic [15:0] cfg, input int row, input int first_row);
    cfg_val = cfg;
    if (first_row) begin
      do_start();
      step(1'b0);
      chk_n(2, "R3");
      chk_acc(0, ent(1'b0, 8'h74, 0), "R2 link read");
      chk_acc(1, ent(1'b1, 8'h74, 32'h03C0), "R3 link up write");
      chk(done_o == 1'b0, "R3 not done", 64'(done_o), 64'(0));
      step(1'b0);
      chk_n(1, "R5");
      chk_acc(0, ent(1'b0, 8'h74, 0), "R5 status read");
    end
    for (int c = 0; c < 4; c++) begin
      step(c == 0);
      if (c == 0) begin
        chk_n(2, "R6 col0 / R10 extra tick");
        chk_acc(0, ent(1'b1, 8'h70, 32'h0), "R6 nway clear");
        chk_acc(1, ent(1'b1, 8'h7C, exp_word(row, 0)), "R6 col0 word");
        base_n = log_n;
        repeat (5) @(negedge clk_i);
        chk(busy_o == 1'b0, "R10 extra tick ignored", 64'(busy_o), 64'(0));
        chk_n(0, "R10 no extra step");
      end else begin
        chk_n(1, "R6 column");
        chk_acc(0, ent(1'b1, 8'h7C, exp_word(row, c)), "R6 column word");
      end
    end
    chk(done_o == (row != 3), "R7 done after row", 64'(done_o), 64'(row != 3));
  endtask

  task automatic t_long_match();
    run_row(16'h7400, 3, 1);
    step(1'b0);
    chk_n(1, "R8 recheck");
    chk_acc(0, ent(1'b0, 8'h74, 0), "R8 recheck read");
    chk(done_o == 1'b1, "R8 long confirmed", 64'(done_o), 64'(1));
  endtask

  task automatic t_long_backoff();
    run_row(16'h7400, 3, 1);
    cfg_val = 16'h3400;
    step(1'b0);
    chk_n(2, "R8 backoff");
    chk_acc(1, ent(1'b1, 8'h7C, 32'hFB38DE03), "R8 backoff word");
    chk(done_o == 1'b0, "R8 continues", 64'(done_o), 64'(0));
    step(1'b0);
    chk_n(4, "R8 retune");
    chk_acc(0, ent(1'b1, 8'h70, 32'h20), "R8 retune cable");
    chk_acc(1, ent(1'b1, 8'h78, 32'h78FA8388), "R8 retune low");
    chk_acc(2, ent(1'b1, 8'h7C, 32'hCB38DE43), "R8 retune high");
    chk_acc(3, ent(1'b1, 8'h70, 32'h0), "R8 retune clear");
    run_row(16'h3400, 2, 0);
    chk(tick_period_o == PW'(BASE), "R11 slow after retune", 64'(tick_period_o), 64'(BASE));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_tick_while_done();
    t_link_down();
    lat = 1; run_row(16'h3400, 2, 1);
    lat = 0; run_row(16'h0400, 0, 1);
    lat = 3; run_row(16'h1C00, 1, 1);
    lat = 2; run_row(16'hB400, 0, 1);
    t_long_match();
    t_long_backoff();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule